// File: doc/BRIEF.md
# Calendar Time Counter Peripheral

This block keeps wall-clock time as a set of calendar counters: seconds, minutes, hours, day of month, day of week, day of year, month and a 12-bit year. It sits behind a simple 32-bit word-addressed register bus with write strobes. Every counter can be read and loaded at its own address. Three read-only packed words return the whole time in three accesses.

A one-cycle `tick_i` pulse comes from an already divided oscillator. A prescaler turns `TICKS_PER_SEC` such pulses into one second. A control register starts or stops counting, holds the prescaler in reset, and switches the calibration counter off. The calibration counter counts ticks up to a programmable interval. At each interval it either removes one second or inserts one, depending on a direction bit.

An increment mask selects which field changes raise the increment flag. Software clears that flag by writing a 1 to it.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the control, calibration and mask registers read 0. The interrupt location register reads 0. The time is 00:00:00, day of month 1, month 1, year 0, day of week 0 and day of year 1.
- R2: The counter registers sit at byte addresses 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34, 0x38 and 0x3C, in the order seconds, minutes, hours, day of month, day of week, day of year, month, year. A write loads the field on the next clock edge, keeping only its low bits (6, 6, 5, 5, 3, 12, 4 and 12 bits). A read returns the field zero-extended.
- R3: The packed words sit at 0x14, 0x18 and 0x1C.
  - Word 0x14 holds seconds in 5:0, minutes in 13:8, hours in 20:16 and day of week in 26:24.
  - Word 0x18 holds day of month in 4:0, month in 11:8 and year in 27:16.
  - Word 0x1C holds day of year in 11:0.
  - All other bits read 0.
- R4: The control register is at 0x08. Bit 0 enables counting. Bit 1 holds the prescaler, the calibration counter and its pending actions at zero. Bit 4 disables calibration. With bit 0 set and bit 1 clear, every `TICKS_PER_SEC`-th tick advances the time by one second. Otherwise the time does not change.
- R5: Seconds and minutes wrap from 59 to 0 and carry into the next field. Hours wrap from 23 to 0 and carry into the day fields.
- R6: On a day carry the following happens.
  - Day of week wraps from 6 to 0.
  - Day of year wraps to 1 after 366 in a year divisible by 4, and after 365 otherwise.
  - Day of month wraps to 1 after the month length (February has 29 days in a year divisible by 4), and then increments the month.
  - Month wraps from 12 to 1 and increments the year.
- R7: The calibration register is at 0x40, with the interval in bits 16:0 and the direction in bit 17. With direction 1 (drop), each time the tick count reaches the interval, the next regular second step is suppressed.
- R8: With direction 0 (add), each time the tick count reaches the interval, one extra second step is made in the first following cycle that has no regular step and no counter write.
- R9: With control bit 4 set, or with an interval of 0, calibration has no effect on counting.
- R10: The mask register is at 0x0C, with bit i belonging to the field at address 0x20+4i. A step that changes a field whose mask bit is 1 sets the increment flag. The flag reads as bit 0 of the interrupt location register at 0x00 and drives `incr_irq_o`. Bit 1 of that register (the alarm event) always reads 0.
- R11: Writing 1 to bit 0 at 0x00 clears the increment flag, and writing 0 leaves it unchanged. A flag set in the same cycle as the clear wins.
- R12: A counter-register write in the cycle that would step the time cancels that step. Writing 0 to seconds therefore never carries into minutes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per divided oscillator period |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| incr_irq_o | output | 1 | Increment flag |

## Verification
The embedded properties check the following on every cycle:
- the prescaler stays bounded;
- no step occurs while counting is stopped or during a counter write;
- a pending drop always swallows the regular step;
- a non-wrapping second step leaves minutes alone;
- a load lands on the next edge;
- the flag never appears with an empty mask and never clears without a clear write.

Only the bench scenarios show the following:
- calendar corners such as a leap-year February, a year end and a 30-day month;
- the packed word layouts;
- the exact number of seconds gained or lost over a calibration interval;
- the masked flag behaviour against a model.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NFIELD = 8;
  localparam int CAL_W  = 17;
  localparam int FVAL_W = 12;

  typedef struct packed {
    logic [11:0] year;
    logic [3:0]  month;
    logic [11:0] doy;
    logic [2:0]  dow;
    logic [4:0]  dom;
    logic [4:0]  hour;
    logic [5:0]  minute;
    logic [5:0]  sec;
  } cal_time_t;

  function automatic logic is_leap(input logic [11:0] y);
    return (y[1:0] == 2'b00);
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] m, input logic [11:0] y);
    case (m)
      4'd2:                      return is_leap(y) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  function automatic logic [11:0] year_days(input logic [11:0] y);
    return is_leap(y) ? 12'd366 : 12'd365;
  endfunction

  // Fields that change when the time advances by one second.
  function automatic logic [NFIELD-1:0] carry_mask(input cal_time_t t);
    logic [NFIELD-1:0] c;
    logic s_w, m_w, h_w, d_w, mo_w;
    s_w  = (t.sec >= 6'd59);
    m_w  = s_w && (t.minute >= 6'd59);
    h_w  = m_w && (t.hour >= 5'd23);
    d_w  = h_w && (t.dom >= month_days(t.month, t.year));
    mo_w = d_w && (t.month >= 4'd12);
    c    = {mo_w, d_w, h_w, h_w, h_w, m_w, s_w, 1'b1};
    return c;
  endfunction

  function automatic cal_time_t advance(input cal_time_t t);
    cal_time_t n;
    logic [NFIELD-1:0] c;
    c = carry_mask(t);
    n = t;
    n.sec = c[1] ? 6'd0 : t.sec + 6'd1;
    if (c[1]) n.minute = c[2] ? 6'd0 : t.minute + 6'd1;
    if (c[2]) n.hour   = c[3] ? 5'd0 : t.hour + 5'd1;
    if (c[3]) begin
      n.dow = (t.dow >= 3'd6) ? 3'd0 : t.dow + 3'd1;
      n.doy = (t.doy >= year_days(t.year)) ? 12'd1 : t.doy + 12'd1;
      n.dom = c[6] ? 5'd1 : t.dom + 5'd1;
    end
    if (c[6]) n.month = c[7] ? 4'd1 : t.month + 4'd1;
    if (c[7]) n.year  = t.year + 12'd1;
    return n;
  endfunction

  function automatic logic [FVAL_W-1:0] get_field(input cal_time_t t, input logic [2:0] sel);
    case (sel)
      3'd0:    return {6'd0, t.sec};
      3'd1:    return {6'd0, t.minute};
      3'd2:    return {7'd0, t.hour};
      3'd3:    return {7'd0, t.dom};
      3'd4:    return {9'd0, t.dow};
      3'd5:    return t.doy;
      3'd6:    return {8'd0, t.month};
      default: return t.year;
    endcase
  endfunction

  function automatic cal_time_t put_field(input cal_time_t t, input logic [2:0] sel,
                                          input logic [FVAL_W-1:0] v);
    cal_time_t n;
    n = t;
    case (sel)
      3'd0:    n.sec    = v[5:0];
      3'd1:    n.minute = v[5:0];
      3'd2:    n.hour   = v[4:0];
      3'd3:    n.dom    = v[4:0];
      3'd4:    n.dow    = v[2:0];
      3'd5:    n.doy    = v;
      3'd6:    n.month  = v[3:0];
      default: n.year   = v;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rtc_sec_gen.sv
module rtc_sec_gen #(
  parameter int TICKS_PER_SEC = 4,
  parameter int CAL_W         = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             cal_on_i,
  input  logic [CAL_W-1:0] cal_val_i,
  input  logic             cal_drop_i,
  input  logic             blocked_i,
  output logic             sec_step_o
);
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] PLAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0]    presc_q;
  logic [CAL_W-1:0] cal_cnt_q;
  logic             skip_q, add_q;
  logic             base_evt, cal_active, cal_hit, extra_evt;
  logic [CAL_W:0]   cal_next;

  assign base_evt   = run_i && tick_i && (presc_q == PLAST);
  assign cal_active = run_i && cal_on_i && (cal_val_i != '0);
  assign cal_next   = {1'b0, cal_cnt_q} + 1'b1;
  assign cal_hit    = cal_active && tick_i && (cal_next >= {1'b0, cal_val_i});
  assign extra_evt  = add_q && run_i && !base_evt && !blocked_i;
  assign sec_step_o = ((base_evt && !skip_q) || extra_evt) && !blocked_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
    end else if (clr_i) begin
      presc_q <= '0;
    end else if (run_i && tick_i) begin
      presc_q <= (presc_q == PLAST) ? '0 : presc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_cnt_q <= '0;
    end else if (clr_i) begin
      cal_cnt_q <= '0;
    end else if (cal_active && tick_i) begin
      cal_cnt_q <= cal_hit ? '0 : cal_next[CAL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= 1'b0;
      add_q  <= 1'b0;
    end else if (clr_i) begin
      skip_q <= 1'b0;
      add_q  <= 1'b0;
    end else begin
      if (cal_hit && cal_drop_i)       skip_q <= 1'b1;
      else if (base_evt)               skip_q <= 1'b0;
      if (cal_hit && !cal_drop_i)      add_q  <= 1'b1;
      else if (extra_evt)              add_q  <= 1'b0;
    end
  end

  p_presc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q <= PLAST);

  p_idle_no_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !sec_step_o);

  p_drop_swallows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (base_evt && skip_q) |-> !sec_step_o);

  p_drop_consumed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (base_evt && skip_q && !clr_i && !(cal_hit && cal_drop_i)) |=> !skip_q);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              wr_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [FVAL_W-1:0] wr_val_i,
  output cal_time_t         time_o,
  output logic [NFIELD-1:0] chg_o
);
  cal_time_t time_q, time_d;

  localparam cal_time_t RESET_TIME = '{year: 12'd0, month: 4'd1, doy: 12'd1, dow: 3'd0,
                                       dom: 5'd1, hour: 5'd0, minute: 6'd0, sec: 6'd0};

  always_comb begin
    time_d = time_q;
    chg_o  = '0;
    if (wr_i) begin
      time_d = put_field(time_q, wr_sel_i, wr_val_i);
    end else if (step_i) begin
      time_d = advance(time_q);
      chg_o  = carry_mask(time_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= RESET_TIME;
    else        time_q <= time_d;
  end

  assign time_o = time_q;

  p_sec_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !wr_i && time_q.sec < 6'd59) |=>
      (time_q.sec == $past(time_q.sec) + 6'd1) && $stable(time_q.minute));

  p_wr_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wr_sel_i == 3'd0) |=> (time_q.sec == $past(wr_val_i[5:0])));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !wr_i) |=> $stable(time_q));

  p_day_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !wr_i && time_q.sec == 6'd59 && time_q.minute == 6'd59 &&
     time_q.hour == 5'd23 && time_q.dom == month_days(time_q.month, time_q.year))
      |=> (time_q.dom == 5'd1));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4,
  parameter int ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              incr_irq_o
);
  localparam logic [ADDR_W-1:0] A_LOC  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_PK0  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_PK1  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_PK2  = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_FLD0 = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_FLD7 = ADDR_W'('h3C);
  localparam logic [ADDR_W-1:0] A_CAL  = ADDR_W'('h40);

  logic              ctl_run_q, ctl_clr_q, ctl_caloff_q;
  logic [NFIELD-1:0] mask_q;
  logic [CAL_W-1:0]  cal_val_q;
  logic              cal_drop_q;
  logic              flag_q;
  logic              cnt_wr, flag_set, flag_clr, sec_step;
  logic [NFIELD-1:0] chg;
  cal_time_t         now;
  logic [13:0]       unused_wdata;

  assign unused_wdata = bus_wdata_i[31:18];

  assign cnt_wr   = bus_we_i && (bus_addr_i >= A_FLD0) && (bus_addr_i <= A_FLD7) &&
                    (bus_addr_i[1:0] == 2'b00);
  assign flag_set = |(chg & mask_q);
  assign flag_clr = bus_we_i && (bus_addr_i == A_LOC) && bus_wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_run_q    <= 1'b0;
      ctl_clr_q    <= 1'b0;
      ctl_caloff_q <= 1'b0;
      mask_q       <= '0;
      cal_val_q    <= '0;
      cal_drop_q   <= 1'b0;
    end else if (bus_we_i) begin
      if (bus_addr_i == A_CTRL) begin
        ctl_run_q    <= bus_wdata_i[0];
        ctl_clr_q    <= bus_wdata_i[1];
        ctl_caloff_q <= bus_wdata_i[4];
      end
      if (bus_addr_i == A_MASK) mask_q <= bus_wdata_i[NFIELD-1:0];
      if (bus_addr_i == A_CAL) begin
        cal_val_q  <= bus_wdata_i[CAL_W-1:0];
        cal_drop_q <= bus_wdata_i[CAL_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (flag_set) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign incr_irq_o = flag_q;

  rtc_sec_gen #(.TICKS_PER_SEC(TICKS_PER_SEC), .CAL_W(CAL_W)) u_secgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .run_i      (ctl_run_q && !ctl_clr_q),
    .clr_i      (ctl_clr_q),
    .cal_on_i   (!ctl_caloff_q),
    .cal_val_i  (cal_val_q),
    .cal_drop_i (cal_drop_q),
    .blocked_i  (cnt_wr),
    .sec_step_o (sec_step)
  );

  rtc_calendar u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (sec_step),
    .wr_i     (cnt_wr),
    .wr_sel_i (bus_addr_i[4:2]),
    .wr_val_i (bus_wdata_i[FVAL_W-1:0]),
    .time_o   (now),
    .chg_o    (chg)
  );

  always_comb begin
    bus_rdata_o = 32'd0;
    case (bus_addr_i)
      A_LOC:  bus_rdata_o = {31'd0, flag_q};
      A_CTRL: bus_rdata_o = {27'd0, ctl_caloff_q, 2'b00, ctl_clr_q, ctl_run_q};
      A_MASK: bus_rdata_o = {{(32-NFIELD){1'b0}}, mask_q};
      A_PK0:  bus_rdata_o = {5'd0, now.dow, 3'd0, now.hour, 2'd0, now.minute, 2'd0, now.sec};
      A_PK1:  bus_rdata_o = {4'd0, now.year, 4'd0, now.month, 3'd0, now.dom};
      A_PK2:  bus_rdata_o = {20'd0, now.doy};
      A_CAL:  bus_rdata_o = {14'd0, cal_drop_q, cal_val_q};
      default: begin
        if ((bus_addr_i >= A_FLD0) && (bus_addr_i <= A_FLD7) && (bus_addr_i[1:0] == 2'b00))
          bus_rdata_o = {20'd0, get_field(now, bus_addr_i[4:2])};
      end
    endcase
  end

  p_write_cancels_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> !sec_step);

  p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  p_flag_needs_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0 && !flag_q) |=> !flag_q);

endmodule

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;
  localparam int TPS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_calendar_core #(.TICKS_PER_SEC(TPS), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .incr_irq_o(irq));

  typedef struct {int sec, mn, hr, dom, dow, doy, mon, yr;} tm_t;

  function automatic int m_len(int mon, int yr);
    int tab[12] = '{31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31};
    if (mon == 2 && yr % 4 == 0) return 29;
    return tab[mon-1];
  endfunction

  function automatic tm_t m_step(tm_t t);
    t.sec++;
    if (t.sec == 60) begin
      t.sec = 0; t.mn++;
      if (t.mn == 60) begin
        t.mn = 0; t.hr++;
        if (t.hr == 24) begin
          t.hr = 0;
          t.dow = (t.dow + 1) % 7;
          t.doy++;
          if (t.doy > ((t.yr % 4 == 0) ? 366 : 365)) t.doy = 1;
          t.dom++;
          if (t.dom > m_len(t.mon, t.yr)) begin
            t.dom = 1; t.mon++;
            if (t.mon > 12) begin t.mon = 1; t.yr = (t.yr + 1) % 4096; end
          end
        end
      end
    end
    return t;
  endfunction

  function automatic logic [31:0] w0(tm_t t);
    return (t.dow << 24) | (t.hr << 16) | (t.mn << 8) | t.sec;
  endfunction
  function automatic logic [31:0] w1(tm_t t);
    return (t.yr << 16) | (t.mon << 8) | t.dom;
  endfunction
  function automatic logic [31:0] w2(tm_t t);
    return t.doy;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_time(tm_t t);
    wr(8'h20, t.sec); wr(8'h24, t.mn); wr(8'h28, t.hr); wr(8'h2C, t.dom);
    wr(8'h30, t.dow); wr(8'h34, t.doy); wr(8'h38, t.mon); wr(8'h3C, t.yr);
  endtask

  task automatic restart(logic [31:0] cal_off);
    wr(8'h08, 32'h2 | cal_off);
    wr(8'h08, 32'h1 | cal_off);
  endtask

  task automatic chk_time(string req, tm_t t);
    logic [31:0] d;
    rd(8'h14, d); chk(req, d, w0(t));
    rd(8'h18, d); chk(req, d, w1(t));
    rd(8'h1C, d); chk(req, d, w2(t));
  endtask

  function automatic tm_t mk(int sec, mn, hr, dom, dow, doy, mon, yr);
    tm_t t;
    t.sec = sec; t.mn = mn; t.hr = hr; t.dom = dom;
    t.dow = dow; t.doy = doy; t.mon = mon; t.yr = yr;
    return t;
  endfunction

  task automatic one_sec(string req, tm_t t);
    set_time(t); restart(32'h10); ticks(TPS);
    chk_time(req, m_step(t));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tm_t t, e;
    void'($urandom(32'd20240229));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h08, d); chk("R1 ctrl", d, 0);
    rd(8'h40, d); chk("R1 cal", d, 0);
    rd(8'h0C, d); chk("R1 mask", d, 0);
    rd(8'h00, d); chk("R1 loc", d, 0);
    chk_time("R1 time", mk(0, 0, 0, 1, 0, 1, 1, 0));

    // R2 per-field load and masking
    wr(8'h20, 32'hFFFF_FFC5); rd(8'h20, d); chk("R2 sec mask", d, 32'h05);
    wr(8'h34, 32'h0000_F16D); rd(8'h34, d); chk("R2 doy mask", d, 32'h16D);
    wr(8'h30, 32'h0000_000E); rd(8'h30, d); chk("R2 dow mask", d, 32'h6);
    wr(8'h3C, 32'h0000_17E8); rd(8'h3C, d); chk("R2 year mask", d, 32'h7E8);

    // R3 packed layout
    t = mk(37, 41, 19, 17, 3, 229, 8, 2024);
    set_time(t); chk_time("R3 packed", t);
    rd(8'h28, d); chk("R2 hour read", d, 19);
    rd(8'h38, d); chk("R2 month read", d, 8);

    // R4 enable and prescaler reset
    wr(8'h08, 32'h10); ticks(2 * TPS); chk_time("R4 disabled", t);
    wr(8'h08, 32'h13); ticks(2 * TPS); chk_time("R4 presc held", t);
    wr(8'h08, 32'h11); ticks(TPS - 1); chk_time("R4 partial", t);
    ticks(1); chk_time("R4 one second", m_step(t));

    // R5 / R6 directed rollovers
    one_sec("R5 min carry", mk(59, 10, 5, 3, 1, 3, 1, 2023));
    one_sec("R5 hour carry", mk(59, 59, 7, 3, 1, 3, 1, 2023));
    one_sec("R6 leap feb", mk(59, 59, 23, 28, 6, 59, 2, 2024));
    one_sec("R6 plain feb", mk(59, 59, 23, 28, 2, 59, 2, 2023));
    one_sec("R6 leap feb29", mk(59, 59, 23, 29, 0, 60, 2, 2024));
    one_sec("R6 year end", mk(59, 59, 23, 31, 2, 366, 12, 2024));
    one_sec("R6 30day", mk(59, 59, 23, 30, 6, 120, 4, 2025));

    // R5 / R6 random starts
    for (int k = 0; k < 40; k++) begin
      int n;
      t.yr  = $urandom % 4096;
      t.mon = 1 + $urandom % 12;
      t.dom = 1 + $urandom % m_len(t.mon, t.yr);
      t.dow = $urandom % 7;
      t.doy = 1 + $urandom % 365;
      t.hr  = ($urandom % 2) ? 23 : $urandom % 24;
      t.mn  = ($urandom % 2) ? 59 : $urandom % 60;
      t.sec = 57 + $urandom % 3;
      if ($urandom % 2) t.dom = m_len(t.mon, t.yr);
      n = 1 + $urandom % 3;
      set_time(t); restart(32'h10); ticks(n * TPS);
      e = t;
      for (int j = 0; j < n; j++) e = m_step(e);
      chk_time("R6 random", e);
    end

    // R12 write on a step cycle cancels the step
    t = mk(59, 20, 1, 5, 4, 5, 1, 2022);
    set_time(t); restart(32'h10); ticks(TPS - 1);
    @(negedge clk); tick = 1'b1; we = 1'b1; addr = 8'h20; wdata = 0;
    @(negedge clk); tick = 1'b0; we = 1'b0;
    t.sec = 0; chk_time("R12 no carry", t);
    ticks(TPS); chk_time("R12 resumes", m_step(t));

    // R10 / R11 increment flag
    t = mk(58, 3, 2, 5, 4, 5, 1, 2022);
    set_time(t); wr(8'h0C, 32'h02); restart(32'h10);
    ticks(TPS); rd(8'h00, d); chk("R10 sec only", d, 0);
    ticks(TPS); rd(8'h00, d); chk("R10 min flag", d, 1);
    chk("R10 irq pin", {31'd0, irq}, 1);
    wr(8'h00, 32'h0); rd(8'h00, d); chk("R11 write0 keeps", d, 1);
    wr(8'h00, 32'h1); rd(8'h00, d); chk("R11 cleared", d, 0);
    wr(8'h0C, 32'h00); ticks(2 * TPS); rd(8'h00, d); chk("R10 masked off", d, 0);
    wr(8'h0C, 32'h01); ticks(TPS); rd(8'h00, d); chk("R10 sec flag", d, 1);
    wr(8'h00, 32'h1);
    wr(8'h0C, 32'h00);

    // R7 drop
    t = mk(10, 0, 0, 1, 0, 1, 1, 2022);
    set_time(t);
    wr(8'h08, 32'h02); wr(8'h40, (1 << 17) | 8); wr(8'h08, 32'h01);
    ticks(3 * TPS); t.sec = 12; chk_time("R7 drop", t);
    // R8 add
    t.sec = 10; set_time(t);
    wr(8'h08, 32'h02); wr(8'h40, 6); wr(8'h08, 32'h01);
    ticks(3 * TPS); t.sec = 15; chk_time("R8 add", t);
    rd(8'h40, d); chk("R8 cal read", d, 6);
    // R9 calibration off
    t.sec = 10; set_time(t); restart(32'h10);
    ticks(3 * TPS); t.sec = 13; chk_time("R9 caloff", t);
    t.sec = 10; set_time(t);
    wr(8'h40, 0); restart(32'h0);
    ticks(3 * TPS); t.sec = 13; chk_time("R9 zero interval", t);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule